// File: doc/BRIEF.md
# Legacy Interrupt Request Register Block

This block is a cut-down legacy interrupt controller that sits behind a byte-wide register bus. Peripherals post and clear request bits through two bitvector inputs. Software controls which requests are forwarded by writing a primary mask register. It retires requests by writing an index to an acknowledge register. One level-sensitive line, `irq_out`, carries the result to an upstream interrupt controller. It is high exactly while at least one pending request is enabled.

A secondary controller is present only in outline. Its mask is stored and read back, but it never interrupts, and its status always reads zero. The block also decodes a speaker-control status port that reflects an external timer output. A set of unused peripheral registers accepts writes and discards them. Every access gets one response after a fixed number of cycles, and that response flags bad accesses.

Top module: `legacy_irq_regs`

## Requirements
- R1: After reset the pending register is 0x00, `irq_out` is low, `rsp_valid` is low, and both mask registers read 0x00. Because the primary mask is held inverted, a 0x00 readback means all eight sources are enabled.
- R2: A byte write to the primary mask (offset 0x10) stores the complement of the byte as the enable set, so a written 1 masks that source. A byte read of 0x10 returns exactly the last value written.
- R3: `irq_out` equals the OR of (pending AND enable) as it stands after each rising edge. It therefore changes at the same edge that a post, clear, acknowledge or primary mask write changes that value.
- R4: A byte write to the acknowledge register (offset 0x08) clears the pending bit whose index is bits 3:0 of the byte. Bits 7:4 are ignored, and an index of 8 to 15 changes nothing.
- R5: In each cycle, bits set in `post_vec` are set in the pending register and bits set in `clr_vec` are cleared. When one bit is both posted and cleared, or both posted and acknowledged, in the same cycle, it ends up set.
- R6: A write to the secondary mask (offset 0x11) stores the byte unchanged, and a read of 0x11 returns it. A read of the secondary status (offset 0x01) returns 0x00. The secondary mask never affects `irq_out`.
- R7: A read of the pending status (offset 0x00) returns the pending value zero-extended to 64 bits, whether `req_wide` is 0 (one byte) or 1 (64-bit). A wide read of any other offset is an error.
- R8: A byte read of the speaker port (offset 0x30) returns 0x20 when `timer2_high` is 1 in the request cycle, and 0x00 otherwise.
- R9: Byte writes to offsets 0x30, 0x40, 0x50, 0x51, 0x52 and 0x09 complete without error and change no state. The following are errors and change no state: any wide write, any write to another unlisted offset, a write to 0x00 or 0x01, and a read of 0x08, 0x09, 0x40 or 0x50 to 0x52.
- R10: Every accepted request gives exactly one response with `rsp_valid` high. The response becomes visible after the RSP_LAT-th rising edge, counting the accepting edge as the first (RSP_LAT is 2 by default). `rsp_rdata` is 0 whenever `rsp_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 1 for a 64-bit access, 0 for a byte access |
| req_addr | input | 8 | Offset within the 0x100-byte window |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data, zero-extended |
| rsp_err | output | 1 | Bad access flag |
| post_vec | input | 8 | Request bits to set this cycle |
| clr_vec | input | 8 | Request bits to clear this cycle |
| timer2_high | input | 1 | External timer channel 2 output level |
| irq_out | output | 1 | Level interrupt to the upstream controller |

## Verification
The assertions assume that the request fields are settled whenever `req_valid` is high, and that `post_vec` and `clr_vec` are known values in every cycle after reset. They make no assumption about how accesses and peripheral events overlap, so a post may land in the same cycle as an acknowledge or a mask write. The stimulus drives every input at the falling edge and holds it for one full cycle. It keeps each input at a defined value from reset onward. Random phases mix sparse post and clear vectors with accesses to both decoded and unlisted offsets, of both widths.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int BYTE_W = 8;
  localparam int WIDE_W = 64;
  localparam int IDX_W  = 4;

  localparam logic [7:0] OFS_PSTAT  = 8'h00;
  localparam logic [7:0] OFS_SSTAT  = 8'h01;
  localparam logic [7:0] OFS_PACK   = 8'h08;
  localparam logic [7:0] OFS_SACK   = 8'h09;
  localparam logic [7:0] OFS_PMASK  = 8'h10;
  localparam logic [7:0] OFS_SMASK  = 8'h11;
  localparam logic [7:0] OFS_SPKR   = 8'h30;
  localparam logic [7:0] OFS_KBD    = 8'h40;
  localparam logic [7:0] OFS_DCMD   = 8'h50;
  localparam logic [7:0] OFS_DMSK   = 8'h51;
  localparam logic [7:0] OFS_DRST   = 8'h52;

  localparam logic [7:0] SPKR_HIGH  = 8'h20;

  typedef struct packed {
    logic              valid;
    logic              err;
    logic [WIDE_W-1:0] data;
  } lic_rsp_t;
endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [7:0]        req_addr,
  input  logic [PEND_W-1:0] pend_q,
  input  logic [PEND_W-1:0] en_q,
  input  logic [BYTE_W-1:0] smask_q,
  input  logic              timer2_high,
  output logic              wr_pmask,
  output logic              wr_smask,
  output logic              wr_ack,
  output lic_rsp_t          rsp_d
);
  logic              bad;
  logic [BYTE_W-1:0] rd_byte;
  logic              rd_wide_ok;
  logic              sel_pmask;
  logic              sel_smask;
  logic              sel_ack;

  always_comb begin
    bad        = 1'b0;
    rd_byte    = '0;
    rd_wide_ok = 1'b0;
    sel_pmask  = 1'b0;
    sel_smask  = 1'b0;
    sel_ack    = 1'b0;
    if (req_write) begin
      unique case (req_addr)
        OFS_PMASK: sel_pmask = 1'b1;
        OFS_SMASK: sel_smask = 1'b1;
        OFS_PACK:  sel_ack   = 1'b1;
        OFS_SPKR, OFS_KBD, OFS_DCMD, OFS_DMSK, OFS_DRST, OFS_SACK: ;
        default:   bad = 1'b1;
      endcase
      if (req_wide) bad = 1'b1;
    end else begin
      unique case (req_addr)
        OFS_PMASK: rd_byte[PEND_W-1:0] = ~en_q;
        OFS_SMASK: rd_byte = smask_q;
        OFS_PSTAT: begin
          rd_byte[PEND_W-1:0] = pend_q;
          rd_wide_ok          = 1'b1;
        end
        OFS_SSTAT: rd_byte = '0;
        OFS_SPKR:  rd_byte = timer2_high ? SPKR_HIGH : '0;
        default:   bad = 1'b1;
      endcase
      if (req_wide && !rd_wide_ok) bad = 1'b1;
    end
  end

  assign wr_pmask   = req_valid && sel_pmask && !bad;
  assign wr_smask   = req_valid && sel_smask && !bad;
  assign wr_ack     = req_valid && sel_ack   && !bad;

  assign rsp_d.valid = req_valid;
  assign rsp_d.err   = req_valid && bad;
  assign rsp_d.data  = (req_valid && !bad && !req_write)
                       ? {{(WIDE_W-BYTE_W){1'b0}}, rd_byte} : '0;

  always_comb begin
    if (req_valid && !req_write && req_addr == OFS_SSTAT)
      a_r6_sec_status_zero: assert (rsp_d.data == '0);
  end
endmodule

// File: rtl/lic_state.sv
module lic_state
  import lic_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pmask,
  input  logic              wr_smask,
  input  logic              wr_ack,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PEND_W-1:0] post_vec,
  input  logic [PEND_W-1:0] clr_vec,
  output logic [PEND_W-1:0] pend_q,
  output logic [PEND_W-1:0] en_q,
  output logic [BYTE_W-1:0] smask_q,
  output logic              irq_q
);
  logic [PEND_W-1:0] pend_d;
  logic [PEND_W-1:0] en_d;
  logic [PEND_W-1:0] ack_vec;
  logic              irq_d;
  logic [IDX_W-1:0]  ack_idx;

  assign ack_idx = wdata[IDX_W-1:0];

  for (genvar g = 0; g < PEND_W; g++) begin : g_ack
    assign ack_vec[g] = wr_ack && (ack_idx == IDX_W'(g));
  end

  always_comb begin
    pend_d = (pend_q & ~(clr_vec | ack_vec)) | post_vec;
    en_d   = wr_pmask ? ~wdata[PEND_W-1:0] : en_q;
    irq_d  = |(pend_d & en_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '1;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        smask_q <= '0;
    else if (wr_smask) smask_q <= wdata;
  end

  a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == |(pend_q & en_q));
  a_r5_post_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vec != '0) |=> ((pend_q & $past(post_vec)) == $past(post_vec)));
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~post_vec) != '0) |=> ((pend_q & $past(clr_vec & ~post_vec)) == '0));
  a_r2_mask_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pmask |=> (en_q == ~$past(wdata[PEND_W-1:0])));
endmodule

// File: rtl/lic_rsp_pipe.sv
module lic_rsp_pipe
  import lic_pkg::*;
#(
  parameter int RSP_LAT = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  lic_rsp_t rsp_d,
  output lic_rsp_t rsp_q
);
  lic_rsp_t stage_q [RSP_LAT];

  for (genvar s = 0; s < RSP_LAT; s++) begin : g_stage
    lic_rsp_t stage_d;
    if (s == 0) begin : g_first
      assign stage_d = rsp_d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign rsp_q = stage_q[RSP_LAT-1];

  a_r10_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q.err |-> (rsp_q.valid && rsp_q.data == '0));
endmodule

// File: rtl/legacy_irq_regs.sv
module legacy_irq_regs
  import lic_pkg::*;
#(
  parameter int PEND_W  = 8,
  parameter int RSP_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [7:0]        req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WIDE_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic [PEND_W-1:0] post_vec,
  input  logic [PEND_W-1:0] clr_vec,
  input  logic              timer2_high,
  output logic              irq_out
);
  logic              rst_meta_q;
  logic              rst_sync_q;
  logic              wr_pmask;
  logic              wr_smask;
  logic              wr_ack;
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] en_q;
  logic [BYTE_W-1:0] smask_q;
  lic_rsp_t          rsp_d;
  lic_rsp_t          rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lic_decode #(.PEND_W(PEND_W)) u_decode (
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_wide    (req_wide),
    .req_addr    (req_addr),
    .pend_q      (pend_q),
    .en_q        (en_q),
    .smask_q     (smask_q),
    .timer2_high (timer2_high),
    .wr_pmask    (wr_pmask),
    .wr_smask    (wr_smask),
    .wr_ack      (wr_ack),
    .rsp_d       (rsp_d)
  );

  lic_state #(.PEND_W(PEND_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_pmask (wr_pmask),
    .wr_smask (wr_smask),
    .wr_ack   (wr_ack),
    .wdata    (req_wdata),
    .post_vec (post_vec),
    .clr_vec  (clr_vec),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .smask_q  (smask_q),
    .irq_q    (irq_out)
  );

  lic_rsp_pipe #(.RSP_LAT(RSP_LAT)) u_rsp (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .rsp_d (rsp_d),
    .rsp_q (rsp_q)
  );

  assign rsp_valid = rsp_q.valid;
  assign rsp_err   = rsp_q.err;
  assign rsp_rdata = rsp_q.data;
endmodule

// File: tb/legacy_irq_regs_tb.sv
module legacy_irq_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam logic [7:0] A_PSTAT = 8'h00, A_SSTAT = 8'h01, A_PACK = 8'h08,
    A_SACK = 8'h09, A_PMASK = 8'h10, A_SMASK = 8'h11, A_SPKR = 8'h30,
    A_KBD = 8'h40, A_DCMD = 8'h50, A_DMSK = 8'h51, A_DRST = 8'h52;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_wide, timer2_high;
  logic [7:0] req_addr, req_wdata, post_vec, clr_vec;
  logic rsp_valid, rsp_err, irq_out;
  logic [63:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_pend, m_en, m_smask;
  logic [63:0] e_data;
  logic e_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_irq_regs #(.PEND_W(8), .RSP_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .post_vec(post_vec), .clr_vec(clr_vec), .timer2_high(timer2_high),
    .irq_out(irq_out));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_read(input logic w, input logic wide, input logic [7:0] a,
                                     input logic t2, output logic [63:0] d, output logic err);
    d = '0;
    err = 1'b0;
    if (w) begin
      err = wide || !(a inside {A_PMASK, A_SMASK, A_PACK, A_SPKR, A_KBD, A_DCMD,
                                A_DMSK, A_DRST, A_SACK});
    end else begin
      case (a)
        A_PMASK: d = {56'd0, ~m_en};
        A_SMASK: d = {56'd0, m_smask};
        A_PSTAT: d = {56'd0, m_pend};
        A_SSTAT: d = '0;
        A_SPKR:  d = t2 ? 64'h20 : 64'h0;
        default: err = 1'b1;
      endcase
      if (wide && a != A_PSTAT) err = 1'b1;
      if (err) d = '0;
    end
  endfunction

  // one cycle: called at a falling edge, returns at the next falling edge
  task automatic step(input logic v, input logic w, input logic wide, input logic [7:0] a,
                      input logic [7:0] wd, input logic [7:0] pv, input logic [7:0] cv,
                      input logic t2);
    logic [7:0] ackv;
    req_valid = v; req_write = w; req_wide = wide; req_addr = a; req_wdata = wd;
    post_vec = pv; clr_vec = cv; timer2_high = t2;
    ackv = '0;
    if (v) begin
      model_read(w, wide, a, t2, e_data, e_err);
      if (w && !e_err) begin
        if (a == A_PMASK) m_en = ~wd;
        if (a == A_SMASK) m_smask = wd;
        if (a == A_PACK && wd[3:0] < 4'd8) ackv[wd[2:0]] = 1'b1;
      end
    end
    m_pend = (m_pend & ~(cv | ackv)) | pv;
    @(negedge clk);
    check("R3 irq level", {63'd0, irq_out}, {63'd0, |(m_pend & m_en)});
  endtask

  task automatic access(input string tag, input logic w, input logic wide, input logic [7:0] a,
                        input logic [7:0] wd, input logic [7:0] pv, input logic [7:0] cv,
                        input logic t2);
    logic [63:0] xd;
    logic xe;
    step(1'b1, w, wide, a, wd, pv, cv, t2);
    xd = e_data; xe = e_err;
    for (int k = 1; k < LAT; k++) begin
      check("R10 no early response", {63'd0, rsp_valid}, 64'd0);
      step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    end
    check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    check({tag, " err"}, {63'd0, rsp_err}, {63'd0, xe});
    check({tag, " data"}, rsp_rdata, xd);
  endtask

  task automatic idle(input logic [7:0] pv, input logic [7:0] cv);
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, pv, cv, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [12];
    addrs = '{A_PSTAT, A_SSTAT, A_PACK, A_SACK, A_PMASK, A_SMASK, A_SPKR,
              A_KBD, A_DCMD, A_DMSK, A_DRST, 8'h3C};
    void'($urandom(32'h1C0FFEE));
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_wide = 0; req_addr = 0; req_wdata = 0;
    post_vec = 0; clr_vec = 0; timer2_high = 0;
    m_pend = '0; m_en = '1; m_smask = '0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {63'd0, irq_out}, 64'd0);
    check("R1 rsp in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {63'd0, irq_out}, 64'd0);
    access("R1 pmask reset", 0, 0, A_PMASK, 0, 0, 0, 0);
    access("R1 smask reset", 0, 0, A_SMASK, 0, 0, 0, 0);
    access("R1 pend reset", 0, 0, A_PSTAT, 0, 0, 0, 0);

    // R2 inverted mask
    access("R2 write pmask", 1, 0, A_PMASK, 8'hF0, 0, 0, 0);
    access("R2 readback", 0, 0, A_PMASK, 0, 0, 0, 0);
    idle(8'h10, 0);          // masked source: irq stays low
    idle(8'h01, 0);          // enabled source: irq rises
    check("R2 irq from enabled bit", {63'd0, irq_out}, 64'd1);

    // R4 acknowledge
    access("R4 ack idx0 high nibble", 1, 0, A_PACK, 8'hA0, 0, 0, 0);
    check("R4 irq after ack", {63'd0, irq_out}, 64'd0);
    access("R4 ack idx9", 1, 0, A_PACK, 8'h09, 0, 0, 0);
    access("R4 pend after idx9", 0, 0, A_PSTAT, 0, 0, 0, 0);
    access("R3 unmask raises", 1, 0, A_PMASK, 8'h00, 0, 0, 0);
    check("R3 irq after unmask", {63'd0, irq_out}, 64'd1);
    access("R4 ack idx4", 1, 0, A_PACK, 8'h04, 0, 0, 0);
    check("R4 irq cleared", {63'd0, irq_out}, 64'd0);

    // R5 post priority
    idle(8'h04, 8'h04);
    access("R5 post beats clear", 0, 0, A_PSTAT, 0, 0, 0, 0);
    idle(0, 8'h04);
    access("R5 post beats ack", 1, 0, A_PACK, 8'h03, 8'h08, 0, 0);
    access("R5 pend bit3", 0, 1, A_PSTAT, 0, 0, 0, 0);

    // R6 secondary
    access("R6 smask write", 1, 0, A_SMASK, 8'h5A, 0, 0, 0);
    access("R6 smask read", 0, 0, A_SMASK, 0, 0, 0, 0);
    access("R6 sstat zero", 0, 0, A_SSTAT, 0, 0, 0, 0);

    // R7 wide access
    idle(8'hC0, 0);
    access("R7 wide pend", 0, 1, A_PSTAT, 0, 0, 0, 0);
    access("R7 wide pmask read", 0, 1, A_PMASK, 0, 0, 0, 0);
    access("R9 wide write", 1, 1, A_PMASK, 8'hFF, 0, 0, 0);
    access("R9 pmask unchanged", 0, 0, A_PMASK, 0, 0, 0, 0);

    // R8 speaker port
    access("R8 spkr high", 0, 0, A_SPKR, 0, 0, 0, 1);
    access("R8 spkr low", 0, 0, A_SPKR, 0, 0, 0, 0);

    // R9 discard and error offsets
    access("R9 kbd write", 1, 0, A_KBD, 8'hFF, 0, 0, 0);
    access("R9 dma cmd write", 1, 0, A_DCMD, 8'hFF, 0, 0, 0);
    access("R9 dma mask write", 1, 0, A_DMSK, 8'hFF, 0, 0, 0);
    access("R9 dma reset write", 1, 0, A_DRST, 8'hFF, 0, 0, 0);
    access("R9 sec ack write", 1, 0, A_SACK, 8'h03, 0, 0, 0);
    access("R9 spkr write", 1, 0, A_SPKR, 8'hFF, 0, 0, 0);
    access("R9 pend intact", 0, 0, A_PSTAT, 0, 0, 0, 0);
    access("R9 unlisted write", 1, 0, 8'h3C, 8'h01, 0, 0, 0);
    access("R9 ack read", 0, 0, A_PACK, 0, 0, 0, 0);
    access("R9 pstat write", 1, 0, A_PSTAT, 8'h00, 0, 0, 0);
    access("R9 pend after bad", 0, 0, A_PSTAT, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] pv, cv, a;
      pv = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
      cv = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      if ($urandom % 3 == 0) begin
        a = ($urandom % 8 == 0) ? 8'($urandom) : addrs[$urandom % 12];
        access("R7 R9 random access", 1'($urandom), ($urandom % 6 == 0), a,
               8'($urandom), pv, cv, 1'($urandom));
      end else begin
        idle(pv, cv);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule